// File: doc/BRIEF.md
# GPIO Interrupt Detect Unit

This block watches up to 32 general-purpose input pins and turns activity on them into interrupt requests. The pins form two 16-bit halves: a low half for pins 0 to 15 and a high half for pins 16 to 31. Each pin has its own settings, stored in 16-bit configuration words:

- level or edge detection;
- polarity in level mode;
- which edges count in edge mode;
- whether its status bit latches an event or just shows the present detect condition.

A status bit asserts a request only when the enable bit of that pin is also set.

The unit puts every pin through a two-flop synchroniser. It drives one combined request line and the 5-bit number of the winning pin. The winner is the lowest-numbered enabled pending pin in the low half. Only when the low half has nothing pending does the search move to the high half. A separate flag shows that nothing is pending.

Software reaches the configuration through a single-cycle write strobe and a combinational read port. The word offsets below are fixed. Bit 1 of the offset picks the high half.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration word reads 0, `irq_req` is 0, `irq_none` is 1 and `irq_idx` is 0.
- R2: A pin change reaches the detect logic through two flops. A level seen at the input before clock edge k affects detection after edge k+1, and not after edge k.
- R3: When the type bit of a pin is 0 (level mode, type words at 0x10 low and 0x12 high), the pin is detected while its synchronised level matches its polarity bit. The polarity words are at 0x14 and 0x16, with 1 meaning active-high and 0 meaning active-low.
- R4: When the type bit is 1 (edge mode) and the rising-select bit is set (words 0x24 and 0x26), a 0-to-1 change of the synchronised level is detected.
- R5: In edge mode a falling-select bit (words 0x20 and 0x22) detects a 1-to-0 change. With both select bits set, both directions are detected. With neither set, the pin never triggers.
- R6: When the hold bit of a pin is 1 (words 0x18 and 0x1A), the status bit latches a detection. It stays set until a write of 1 to that bit at the status word (0x08 low, 0x0A high). Writing 0 to a status bit changes nothing.
- R7: When the hold bit is 0, the status bit shows the present detect condition in the same cycle. An edge therefore gives a status pulse one cycle long.
- R8: If a clear write and a new detection of the same latched pin fall in the same cycle, the status bit stays set.
- R9: A pin contributes to `irq_req` only when both its status bit and its enable bit are 1. The enable words are at 0x0C and 0x0E.
- R10: `irq_idx` gives the lowest-numbered enabled pending pin of the low half. When the low half has none, it gives the lowest-numbered such pin of the high half.
- R11: When no enabled pending pin exists, `irq_none` is 1, `irq_req` is 0 and `irq_idx` is 0.
- R12: Each configuration word and each status word reads back at its offset. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous pin levels |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 6 | Write word offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read word offset |
| rd_data | output | 16 | Read data, combinational |
| irq_req | output | 1 | Combined interrupt request |
| irq_idx | output | 5 | Number of the winning pin |
| irq_none | output | 1 | No enabled pin is pending |

## Verification
The bench aims at the cycle in which a clear write meets a fresh edge. A design that let the clear win would lose that event, and the pin's status would read 0. It checks the two-edge synchroniser lag: a design with one flop too few or too many would raise the request a cycle early or late. It checks priority with pending pins in both halves, where a plain highest-first or high-half-first encoder would report the wrong pin. Finally, it checks pass-through edge pulses and writes of 0 to status bits. There, a design that latched in through mode or cleared on a 0 would show a status that lasts too long or vanishes.

// File: rtl/gid_pkg.sv
package gid_pkg;

    localparam int unsigned GID_AW = 6;

    // Word offsets of the low half; bit 1 of an offset selects the high half.
    localparam logic [GID_AW-1:0] OFS_STAT = 6'h08;
    localparam logic [GID_AW-1:0] OFS_EN   = 6'h0C;
    localparam logic [GID_AW-1:0] OFS_TYPE = 6'h10;
    localparam logic [GID_AW-1:0] OFS_POL  = 6'h14;
    localparam logic [GID_AW-1:0] OFS_HOLD = 6'h18;
    localparam logic [GID_AW-1:0] OFS_FALL = 6'h20;
    localparam logic [GID_AW-1:0] OFS_RISE = 6'h24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_TYPE,
        SEL_POL,
        SEL_HOLD,
        SEL_FALL,
        SEL_RISE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [GID_AW-1:0] a);
        logic [GID_AW-1:0] base;
        base = {a[GID_AW-1:2], 1'b0, a[0]};
        case (base)
            OFS_STAT: return SEL_STAT;
            OFS_EN:   return SEL_EN;
            OFS_TYPE: return SEL_TYPE;
            OFS_POL:  return SEL_POL;
            OFS_HOLD: return SEL_HOLD;
            OFS_FALL: return SEL_FALL;
            OFS_RISE: return SEL_RISE;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/gid_pin_detect.sv
module gid_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,        // synchronised pin level
    input  logic edge_mode,  // 1 edge, 0 level
    input  logic act_high,   // level polarity
    input  logic hold,       // 1 latched, 0 pass-through
    input  logic fall_en,
    input  logic rise_en,
    input  logic clr,        // write-one-to-clear for this pin
    output logic stat_vis,   // status as seen by software and priority
    output logic stat_lat    // latched status register
);

    typedef struct packed {
        logic prev;
        logic stat;
    } pin_t;

    pin_t p_d, p_q;
    logic det;

    always_comb begin
        if (edge_mode) begin
            det = (rise_en & lvl & ~p_q.prev) | (fall_en & ~lvl & p_q.prev);
        end else begin
            det = act_high ? lvl : ~lvl;
        end

        p_d      = p_q;
        p_d.prev = lvl;
        // A fresh detection outranks a clear in the same cycle.
        p_d.stat = hold ? (det | (p_q.stat & ~clr)) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign stat_vis = hold ? p_q.stat : det;
    assign stat_lat = p_q.stat;

endmodule

// File: rtl/gid_prio.sv
module gid_prio #(
    parameter  int unsigned DW = 16,
    localparam int unsigned NP = 2 * DW,
    localparam int unsigned IW = $clog2(NP),
    localparam int unsigned HW = $clog2(DW)
) (
    input  logic [NP-1:0] pend,
    output logic          any,
    output logic [IW-1:0] idx
);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic          hit;
        logic [HW-1:0] pos;
        always_comb begin
            hit = 1'b0;
            pos = '0;
            for (int i = DW - 1; i >= 0; i--) begin
                if (pend[h*DW + i]) begin
                    hit = 1'b1;
                    pos = HW'(i);
                end
            end
        end
    end

    always_comb begin
        any = g_half[0].hit | g_half[1].hit;
        if (g_half[0].hit)      idx = IW'(g_half[0].pos);
        else if (g_half[1].hit) idx = IW'(DW) + IW'(g_half[1].pos);
        else                    idx = '0;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gid_pkg::*;
#(
    parameter  int unsigned DW = 16,
    localparam int unsigned NP = 2 * DW,
    localparam int unsigned IW = $clog2(NP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     pin_in,
    input  logic              wr_en,
    input  logic [GID_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [GID_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_req,
    output logic [IW-1:0]     irq_idx,
    output logic              irq_none
);

    typedef struct packed {
        logic [NP-1:0] en;
        logic [NP-1:0] typ;
        logic [NP-1:0] pol;
        logic [NP-1:0] hold;
        logic [NP-1:0] fall;
        logic [NP-1:0] rise;
    } cfg_t;

    cfg_t          cfg_d, cfg_q;
    logic [NP-1:0] clr_m;
    logic [NP-1:0] sync_lvl;
    logic [NP-1:0] stat_vis;
    logic [NP-1:0] stat_lat;
    logic [NP-1:0] pend;
    reg_sel_e      wsel, rsel;
    logic [NP-1:0] rd_src;

    function automatic logic [NP-1:0] lane_put(input logic [NP-1:0] old,
                                               input logic hi,
                                               input logic [DW-1:0] d);
        logic [NP-1:0] r;
        r = old;
        if (hi) r[NP-1:DW] = d;
        else    r[DW-1:0]  = d;
        return r;
    endfunction

    // Next-state of the configuration and the clear mask of this cycle
    always_comb begin
        cfg_d = cfg_q;
        clr_m = '0;
        wsel  = decode_ofs(wr_addr);
        if (wr_en) begin
            case (wsel)
                SEL_STAT: clr_m      = lane_put('0, wr_addr[1], wr_data);
                SEL_EN:   cfg_d.en   = lane_put(cfg_q.en,   wr_addr[1], wr_data);
                SEL_TYPE: cfg_d.typ  = lane_put(cfg_q.typ,  wr_addr[1], wr_data);
                SEL_POL:  cfg_d.pol  = lane_put(cfg_q.pol,  wr_addr[1], wr_data);
                SEL_HOLD: cfg_d.hold = lane_put(cfg_q.hold, wr_addr[1], wr_data);
                SEL_FALL: cfg_d.fall = lane_put(cfg_q.fall, wr_addr[1], wr_data);
                SEL_RISE: cfg_d.rise = lane_put(cfg_q.rise, wr_addr[1], wr_data);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    gid_sync #(.W(NP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    for (genvar g = 0; g < NP; g++) begin : g_pin
        gid_pin_detect u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (sync_lvl[g]),
            .edge_mode (cfg_q.typ[g]),
            .act_high  (cfg_q.pol[g]),
            .hold      (cfg_q.hold[g]),
            .fall_en   (cfg_q.fall[g]),
            .rise_en   (cfg_q.rise[g]),
            .clr       (clr_m[g]),
            .stat_vis  (stat_vis[g]),
            .stat_lat  (stat_lat[g])
        );
    end

    assign pend = stat_vis & cfg_q.en;

    gid_prio #(.DW(DW)) u_prio (
        .pend (pend),
        .any  (irq_req),
        .idx  (irq_idx)
    );

    assign irq_none = ~irq_req;

    // Read mux
    always_comb begin
        rsel = decode_ofs(rd_addr);
        case (rsel)
            SEL_STAT: rd_src = stat_vis;
            SEL_EN:   rd_src = cfg_q.en;
            SEL_TYPE: rd_src = cfg_q.typ;
            SEL_POL:  rd_src = cfg_q.pol;
            SEL_HOLD: rd_src = cfg_q.hold;
            SEL_FALL: rd_src = cfg_q.fall;
            SEL_RISE: rd_src = cfg_q.rise;
            default:  rd_src = '0;
        endcase
        rd_data = rd_addr[1] ? rd_src[NP-1:DW] : rd_src[DW-1:0];
    end

endmodule

// File: rtl/gid_chk.sv
module gid_chk
    import gid_pkg::*;
#(
    parameter  int unsigned DW = 16,
    localparam int unsigned NP = 2 * DW,
    localparam int unsigned IW = $clog2(NP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NP-1:0]     pin_in,
    input logic              wr_en,
    input logic [GID_AW-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              irq_req,
    input logic [IW-1:0]     irq_idx,
    input logic              irq_none,
    input logic [NP-1:0]     sync_lvl,
    input logic [NP-1:0]     stat_vis,
    input logic [NP-1:0]     stat_lat,
    input logic [NP-1:0]     en_q,
    input logic [NP-1:0]     hold_q
);

    localparam logic [NP-1:0] LOW_MASK = {{DW{1'b0}}, {DW{1'b1}}};

    logic [1:0]    cyc_q;
    logic [NP-1:0] clr_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    always_comb begin
        clr_chk = '0;
        if (wr_en && {wr_addr[GID_AW-1:2], 1'b0, wr_addr[0]} == OFS_STAT) begin
            if (wr_addr[1]) clr_chk[NP-1:DW] = wr_data;
            else            clr_chk[DW-1:0]  = wr_data;
        end
    end

    AST_NONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_none == !irq_req); // R11

    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        irq_none |-> irq_idx == '0); // R11

    AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (stat_vis[irq_idx] && en_q[irq_idx])); // R9

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((stat_vis & en_q) & ((NP'(1) << irq_idx) - NP'(1))) == '0); // R10

    AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_idx >= IW'(DW)) |-> ((stat_vis & en_q) & LOW_MASK) == '0); // R10

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> sync_lvl == $past(pin_in, 2)); // R2

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_lat & hold_q & ~clr_chk) & ~stat_lat) == '0); // R6

endmodule

bind gpio_irq_detect gid_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_req  (irq_req),
    .irq_idx  (irq_idx),
    .irq_none (irq_none),
    .sync_lvl (sync_lvl),
    .stat_vis (stat_vis),
    .stat_lat (stat_lat),
    .en_q     (cfg_q.en),
    .hold_q   (cfg_q.hold)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = 6'h08;
    logic [15:0] rd_data;
    logic        irq_req;
    logic [4:0]  irq_idx;
    logic        irq_none;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    gpio_irq_detect i_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_none(irq_none)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_s1, m_s2, m_prev, m_st;
    logic [31:0] m_en, m_typ, m_pol, m_hold, m_fall, m_rise;

    function automatic logic [31:0] m_detect();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (m_typ[i])
                r[i] = (m_rise[i] && m_s2[i] && !m_prev[i]) ||
                       (m_fall[i] && !m_s2[i] && m_prev[i]);
            else
                r[i] = m_pol[i] ? m_s2[i] : !m_s2[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_visible();
        logic [31:0] d, r;
        d = m_detect();
        for (int i = 0; i < 32; i++) r[i] = m_hold[i] ? m_st[i] : d[i];
        return r;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic hi,
                                          input logic [15:0] d);
        return hi ? {d, old[15:0]} : {old[31:16], d};
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        logic [31:0] v;
        case (a & 6'h3D)
            6'h08:   v = m_visible();
            6'h0C:   v = m_en;
            6'h10:   v = m_typ;
            6'h14:   v = m_pol;
            6'h18:   v = m_hold;
            6'h20:   v = m_fall;
            6'h24:   v = m_rise;
            default: v = '0;
        endcase
        return a[1] ? v[31:16] : v[15:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_st} = '0;
            {m_en, m_typ, m_pol, m_hold, m_fall, m_rise} = '0;
        end else begin
            logic [31:0] d, clr, nst;
            d   = m_detect();
            clr = '0;
            if (wr_en && (wr_addr & 6'h3D) == 6'h08) clr = merge('0, wr_addr[1], wr_data);
            for (int i = 0; i < 32; i++)
                nst[i] = m_hold[i] ? (d[i] || (m_st[i] && !clr[i])) : 1'b0;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
            if (wr_en) begin
                case (wr_addr & 6'h3D)
                    6'h0C: m_en   = merge(m_en,   wr_addr[1], wr_data);
                    6'h10: m_typ  = merge(m_typ,  wr_addr[1], wr_data);
                    6'h14: m_pol  = merge(m_pol,  wr_addr[1], wr_data);
                    6'h18: m_hold = merge(m_hold, wr_addr[1], wr_data);
                    6'h20: m_fall = merge(m_fall, wr_addr[1], wr_data);
                    6'h24: m_rise = merge(m_rise, wr_addr[1], wr_data);
                    default: ;
                endcase
            end
            m_st = nst;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every cycle, well after the edge: compare outputs with the model
    always @(posedge clk) begin
        #3;
        if (rst_n && chk_on) begin
            logic [31:0] pend;
            int          win;
            pend = m_visible() & m_en;
            win  = -1;
            for (int i = 31; i >= 0; i--) if (pend[i]) win = i;
            check(cur_req, "irq_req",  32'(irq_req),  32'(win >= 0));
            check(cur_req, "irq_none", 32'(irq_none), 32'(win < 0));
            check(cur_req, "irq_idx",  32'(irq_idx),  (win >= 0) ? 32'(win) : 32'd0);
            check(cur_req, "rd_data",  32'(rd_data),  32'(m_read(rd_addr)));
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [5:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        logic [31:0] lf;
        logic [5:0]  offs [14];
        offs = '{6'h08, 6'h0A, 6'h0C, 6'h0E, 6'h10, 6'h12, 6'h14,
                 6'h16, 6'h18, 6'h1A, 6'h20, 6'h22, 6'h24, 6'h26};

        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk_on = 1'b1;

        // R1: reset state
        cur_req = "R1";
        check("R1", "irq_none after reset", 32'(irq_none), 32'd1);
        check("R1", "irq_idx after reset",  32'(irq_idx),  32'd0);
        for (int k = 2; k < 14; k++) begin
            peek(offs[k], v);
            check("R1", "config word after reset", 32'(v), 32'd0);
        end

        // R12: readback, unmapped offsets
        cur_req = "R12";
        wr(6'h10, 16'hA5C3); wr(6'h22, 16'h1234); wr(6'h30, 16'hFFFF); wr(6'h0D, 16'hFFFF);
        peek(6'h10, v); check("R12", "type low readback", 32'(v), 32'hA5C3);
        peek(6'h22, v); check("R12", "fall high readback", 32'(v), 32'h1234);
        peek(6'h30, v); check("R12", "unmapped read", 32'(v), 32'd0);
        peek(6'h0C, v); check("R12", "odd-offset write ignored", 32'(v), 32'd0);
        wr(6'h10, 16'h0000); wr(6'h22, 16'h0000);

        // R2 / R3: level mode, active-high, synchroniser lag
        cur_req = "R3";
        wr(6'h0C, 16'hFFFF); wr(6'h0E, 16'hFFFF);
        wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF);
        idle(3);
        check("R3", "active-high low pins idle", 32'(irq_none), 32'd1);
        cur_req = "R2";
        pin_in = 32'h0000_0020;
        @(negedge clk);
        check("R2", "one edge after change, not yet seen", 32'(irq_req), 32'd0);
        @(negedge clk);
        check("R2", "two edges after change, seen", 32'(irq_req), 32'd1);
        check("R2", "index of pin 5", 32'(irq_idx), 32'd5);
        cur_req = "R3";
        wr(6'h14, 16'hFFDF);
        check("R3", "active-low pin 5 high not detected", 32'(irq_none), 32'd1);
        pin_in = 32'h0000_0000;
        idle(3);
        check("R3", "active-low pin 5 low detected", 32'(irq_idx), 32'd5);
        wr(6'h14, 16'hFFFF);

        // R10: priority between halves
        cur_req = "R10";
        pin_in = 32'h0010_0008;
        idle(3);
        check("R10", "low half wins over high", 32'(irq_idx), 32'd3);
        pin_in = 32'h8010_0000;
        idle(3);
        check("R10", "lowest of high half", 32'(irq_idx), 32'd20);
        cur_req = "R9";
        wr(6'h0E, 16'hFFEF);
        check("R9", "masked pin 20 skipped", 32'(irq_idx), 32'd31);
        wr(6'h0E, 16'h0000);
        check("R9", "all high masked", 32'(irq_none), 32'd1);
        cur_req = "R11";
        pin_in = 32'h0000_0000;
        wr(6'h0E, 16'hFFFF);
        idle(3);
        check("R11", "none pending index zero", 32'(irq_idx), 32'd0);

        // R4 / R5: edge mode, latched
        cur_req = "R4";
        wr(6'h18, 16'hFFFF); wr(6'h1A, 16'hFFFF);
        wr(6'h24, 16'h0F0F); wr(6'h20, 16'h0FF0);
        wr(6'h10, 16'hFFFF); wr(6'h12, 16'hFFFF);
        idle(2);
        pin_in = 32'h0000_FFFF;
        idle(3);
        peek(6'h08, v); check("R4", "rising-select pins latched", 32'(v), 32'h0F0F);
        cur_req = "R5";
        pin_in = 32'h0000_0000;
        idle(3);
        peek(6'h08, v); check("R5", "falling and both-edge pins latched", 32'(v), 32'h0FFF);
        peek(6'h0A, v); check("R5", "high half no events", 32'(v), 32'h0000);

        // R6: write-one-to-clear
        cur_req = "R6";
        wr(6'h08, 16'h0000);
        peek(6'h08, v); check("R6", "write of zero keeps status", 32'(v), 32'h0FFF);
        wr(6'h08, 16'h0003);
        peek(6'h08, v); check("R6", "clear of pins 0,1", 32'(v), 32'h0FFC);
        check("R6", "index after clear", 32'(irq_idx), 32'd2);
        wr(6'h08, 16'h0FFC);
        check("R6", "all cleared", 32'(irq_none), 32'd1);

        // R8: clear meets a fresh edge in the same cycle
        cur_req = "R8";
        pin_in = 32'h0000_0001;
        idle(2);
        wr(6'h08, 16'h0001);
        peek(6'h08, v); check("R8", "detection outranks clear", 32'(v), 32'h0001);
        wr(6'h08, 16'h0001);
        peek(6'h08, v); check("R8", "later clear takes effect", 32'(v), 32'h0000);

        // R7: pass-through, edge pulse and level follow
        cur_req = "R7";
        wr(6'h18, 16'h0000);
        pin_in = 32'h0000_0000;
        idle(3);
        pin_in = 32'h0000_0001;
        idle(2);
        check("R7", "through edge pulse present", 32'(irq_req), 32'd1);
        @(negedge clk);
        check("R7", "through edge pulse gone", 32'(irq_req), 32'd0);
        wr(6'h10, 16'h0000);
        peek(6'h08, v); check("R7", "through level follows pin", 32'(v & 16'h0001), 32'h0001);

        // Mixed random stimulus, compared against the model every cycle
        cur_req = "R3/R4/R5/R6/R7/R9/R10";
        lf = 32'h1ACE_B00C;
        for (int c = 0; c < 3000; c++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            if (lf[2:0] == 3'd0) pin_in = pin_in ^ lf;
            rd_addr = offs[c % 14];
            if (lf[7:4] == 4'd3) begin
                wr(lf[10] ? 6'h34 : offs[lf[19:16] % 14], lf[31:16]);
            end else begin
                @(negedge clk);
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule